// File: doc/BRIEF.md
# Read Auto-Precharge Bank Timing Tracker

This block follows the state of a single DRAM bank from the controller's side of the command bus. Every clock it takes one command code and a burst-chop flag. It decides whether the command is legal for the bank at that moment and updates its view of the bank: open, closing after a read with auto precharge, or precharging and waiting for the next activate. A read with auto precharge does not start the precharge at a fixed offset. The internal precharge starts at the first cycle in which both the read-to-precharge delay since the read and the minimum row-active time since the activate have run out. The next activate is then gated by both the precharge time and the row-cycle time.

For every accepted read, the block also produces a data-valid window. The window starts at read latency (CAS latency plus additive latency) and lasts four clocks for a full eight-beat burst or two clocks for a chopped four-beat burst, since beats arrive two per clock. A one-clock strobe preamble indicator precedes each window. Latencies and row timings are sampled while reset is held. The read-to-precharge delay is decoded from a 3-bit code. A command that breaks a timing rule raises a sticky violation flag and is otherwise dropped.

Top module: `rdap_bank_tracker`

## Requirements
- R1: In the first cycles after reset is released: bank_open_o=0, act_ok_o=1, pre_busy_o=0, dvalid_o=0, viol_o=0.
- R2: Command codes on cmd_i are 0 deselect, 1 activate, 2 read, 3 read with auto precharge, 4 precharge. An activate in a cycle where act_ok_o=1 makes bank_open_o=1 and act_ok_o=0 from the next cycle.
- R3: A legal read (code 2 or 3) with chop_i=0 in cycle r drives dvalid_o=1 in cycles r+RL to r+RL+3 and 0 in cycle r+RL-1, where RL = cl_i + al_i as captured at reset. Reads 4 cycles apart give one unbroken window.
- R4: A legal read with chop_i=1 in cycle r drives dvalid_o=1 only in cycles r+RL and r+RL+1.
- R5: dqs_pre_o is 1 in cycle r+RL-1 of each legal read unless dvalid_o is already 1 in that cycle. It is 0 everywhere else.
- R6: The 3-bit code rtp_code_i selects the read-to-precharge delay tRTP = 5 + code for codes 0 to 5. Codes 6 and 7 select 12 clocks.
- R7: After a legal read with auto precharge in cycle r to a bank activated in cycle a, precharge starts in cycle s = max(r+tRTP, a+tRAS). bank_open_o stays 1 up to and including s, is 0 from s+1, and pre_busy_o is 1 from s+1 to s+tRP-1.
- R8: After precharge starts in cycle s, act_ok_o becomes 1 in cycle max(s+tRP, a+tRC) and not earlier. pre_busy_o is 0 from s+tRP on.
- R9: A precharge (code 4) is legal only while the bank is open with no auto precharge pending, at least tRAS cycles after the activate and at least tRTP cycles after the last read. A legal one makes bank_open_o=0 in the next cycle and starts the precharge timing as in R8.
- R10: An activate while act_ok_o=0, a read while the bank is not open, while an auto precharge is pending or fewer than 4 cycles after the previous read, and an illegal precharge all set viol_o=1 from the next cycle. The command has no other effect. viol_o is cleared only by reset.
- R11: Deselect and the reserved codes 5, 6 and 7 change neither the bank state, the timing nor viol_o.
- R12: cl_i, al_i, trp_i, tras_i, trc_i and rtp_code_i are sampled only while rst_n=0. Changing them after reset has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is sampled while low |
| cmd_i | input | 3 | Command code for this cycle |
| chop_i | input | 1 | Burst chop to four beats for a read |
| cl_i | input | TW | CAS latency in clocks |
| al_i | input | TW | Additive latency in clocks |
| trp_i | input | TW | Precharge time in clocks |
| tras_i | input | TW | Minimum row-active time in clocks |
| trc_i | input | TW | Minimum row-cycle time in clocks |
| rtp_code_i | input | 3 | Read-to-precharge delay code |
| bank_open_o | output | 1 | Row is open, including while an auto precharge is pending |
| pre_busy_o | output | 1 | Precharge running, precharge time not yet elapsed |
| act_ok_o | output | 1 | An activate this cycle is legal |
| dvalid_o | output | 1 | Read data beats expected in this cycle |
| dqs_pre_o | output | 1 | Strobe preamble cycle before a data window |
| viol_o | output | 1 | Sticky timing-violation flag |

## Verification
The auto-precharge start is tried in two arrangements, one where the row-active time dominates and one where the read-to-precharge delay dominates. The following activate is also tried both where the row-cycle time gates it and where the precharge time gates it, so an implementation that uses only one limit of each pair is exposed. Reads are issued as full bursts, chopped bursts and back-to-back bursts, which separates window length, window start and preamble suppression. A second reset with a different configuration and a fallback delay code shows that the timing follows the values sampled at reset and not the live inputs. Early activates, early precharges and too-close reads then show that illegal commands only raise the flag.

// File: rtl/bktrk_pkg.sv
package bktrk_pkg;

    typedef enum logic [2:0] {
        CMD_DES = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_RDA = 3'd3,
        CMD_PRE = 3'd4
    } cmd_e;

    typedef enum logic [1:0] {
        BK_CLOSED  = 2'd0,
        BK_OPEN    = 2'd1,
        BK_CLOSING = 2'd2
    } bank_st_e;

    // Clocks per burst at two beats per clock.
    localparam int BURST_CLKS = 4;
    localparam int CHOP_CLKS  = 2;

    // Read-to-precharge code table: linear part and fallback.
    localparam int RTP_BASE     = 5;
    localparam int RTP_LAST_LIN = 5;
    localparam int RTP_FALLBACK = 12;

endpackage

// File: rtl/bktrk_rtp_decode.sv
module bktrk_rtp_decode #(
    parameter int TW = 5
) (
    input  logic [2:0]    code_i,
    output logic [TW-1:0] trtp_o
);
    import bktrk_pkg::*;

    always_comb begin
        if (int'(code_i) <= RTP_LAST_LIN) begin
            trtp_o = TW'(RTP_BASE + int'(code_i));
        end else begin
            trtp_o = TW'(RTP_FALLBACK);
        end
    end

endmodule

// File: rtl/bktrk_elapsed.sv
module bktrk_elapsed #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] SAT = {W{1'b1}};

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (restart_i) begin
            cnt_d = W'(1);
        end else if (cnt_q == SAT) begin
            cnt_d = cnt_q;
        end else begin
            cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= SAT;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/bktrk_read_window.sv
module bktrk_read_window #(
    parameter int RLW   = 6,
    parameter int DEPTH = 65
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fire_i,
    input  logic           chop_i,
    input  logic [RLW-1:0] rl_i,
    output logic           dvalid_o,
    output logic           preamble_o
);
    import bktrk_pkg::*;

    typedef struct packed {
        logic [DEPTH-1:0] rd;
        logic [DEPTH-1:0] ch;
    } hist_t;

    hist_t hist_d, hist_q;
    logic  dv;
    int    idx;
    int    pidx;

    always_comb begin
        hist_d.rd = {hist_q.rd[DEPTH-2:0], fire_i};
        hist_d.ch = {hist_q.ch[DEPTH-2:0], fire_i & chop_i};
    end

    always_comb begin
        dv  = 1'b0;
        idx = 0;
        for (int j = 0; j < BURST_CLKS; j++) begin
            idx = int'(rl_i) - 1 + j;
            if (idx >= 0 && idx < DEPTH) begin
                if (hist_q.rd[idx] && (j < CHOP_CLKS || !hist_q.ch[idx])) begin
                    dv = 1'b1;
                end
            end
        end
    end

    always_comb begin
        preamble_o = 1'b0;
        pidx       = int'(rl_i) - 2;
        if (pidx >= 0 && pidx < DEPTH) begin
            preamble_o = hist_q.rd[pidx] && !dv;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end

    assign dvalid_o = dv;

endmodule

// File: rtl/rdap_bank_tracker.sv
module rdap_bank_tracker #(
    parameter int TW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    cmd_i,
    input  logic          chop_i,
    input  logic [TW-1:0] cl_i,
    input  logic [TW-1:0] al_i,
    input  logic [TW-1:0] trp_i,
    input  logic [TW-1:0] tras_i,
    input  logic [TW-1:0] trc_i,
    input  logic [2:0]    rtp_code_i,
    output logic          bank_open_o,
    output logic          pre_busy_o,
    output logic          act_ok_o,
    output logic          dvalid_o,
    output logic          dqs_pre_o,
    output logic          viol_o
);
    import bktrk_pkg::*;

    localparam int CW      = TW + 1;
    localparam int RLW     = TW + 1;
    localparam int RL_MAX  = 2 * ((1 << TW) - 1);
    localparam int HIST    = RL_MAX + BURST_CLKS - 1;
    localparam int NCNT    = 3;
    localparam int IDX_ACT = 0;
    localparam int IDX_RD  = 1;
    localparam int IDX_PRE = 2;

    typedef struct packed {
        bank_st_e       st;
        logic           viol;
        logic [RLW-1:0] rl;
        logic [TW-1:0]  trp;
        logic [TW-1:0]  tras;
        logic [TW-1:0]  trc;
        logic [TW-1:0]  trtp;
    } trk_t;

    trk_t            trk_d, trk_q, trk_rst;
    logic [TW-1:0]   trtp_dec;
    logic [NCNT-1:0] restart;
    logic [CW-1:0]   elapsed [NCNT];
    logic            act_ok, rd_ok, pre_ok, ap_due, rd_fire;
    logic            ras_met, rc_met, rp_met, rtp_met, ccd_met;

    bktrk_rtp_decode #(.TW(TW)) u_rtp (
        .code_i (rtp_code_i),
        .trtp_o (trtp_dec)
    );

    // One saturating elapsed-time counter per event kind.
    for (genvar g = 0; g < NCNT; g++) begin : g_elapsed
        bktrk_elapsed #(.W(CW)) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .restart_i (restart[g]),
            .cnt_o     (elapsed[g])
        );
    end

    bktrk_read_window #(.RLW(RLW), .DEPTH(HIST)) u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire_i     (rd_fire),
        .chop_i     (chop_i),
        .rl_i       (trk_q.rl),
        .dvalid_o   (dvalid_o),
        .preamble_o (dqs_pre_o)
    );

    always_comb begin
        trk_rst      = '0;
        trk_rst.st   = BK_CLOSED;
        trk_rst.rl   = RLW'(cl_i) + RLW'(al_i);
        trk_rst.trp  = trp_i;
        trk_rst.tras = tras_i;
        trk_rst.trc  = trc_i;
        trk_rst.trtp = trtp_dec;
    end

    always_comb begin
        ras_met = elapsed[IDX_ACT] >= CW'(trk_q.tras);
        rc_met  = elapsed[IDX_ACT] >= CW'(trk_q.trc);
        rp_met  = elapsed[IDX_PRE] >= CW'(trk_q.trp);
        rtp_met = elapsed[IDX_RD]  >= CW'(trk_q.trtp);
        ccd_met = elapsed[IDX_RD]  >= CW'(BURST_CLKS);

        act_ok = (trk_q.st == BK_CLOSED)  && rp_met && rc_met;
        rd_ok  = (trk_q.st == BK_OPEN)    && ccd_met;
        pre_ok = (trk_q.st == BK_OPEN)    && ras_met && rtp_met;
        ap_due = (trk_q.st == BK_CLOSING) && ras_met && rtp_met;
    end

    always_comb begin
        trk_d   = trk_q;
        restart = '0;
        rd_fire = 1'b0;

        if (ap_due) begin
            trk_d.st         = BK_CLOSED;
            restart[IDX_PRE] = 1'b1;
        end

        case (cmd_i)
            CMD_ACT: begin
                if (act_ok) begin
                    trk_d.st         = BK_OPEN;
                    restart[IDX_ACT] = 1'b1;
                end else begin
                    trk_d.viol = 1'b1;
                end
            end
            CMD_RD, CMD_RDA: begin
                if (rd_ok) begin
                    restart[IDX_RD] = 1'b1;
                    rd_fire         = 1'b1;
                    if (cmd_i == CMD_RDA) begin
                        trk_d.st = BK_CLOSING;
                    end
                end else begin
                    trk_d.viol = 1'b1;
                end
            end
            CMD_PRE: begin
                if (pre_ok) begin
                    trk_d.st         = BK_CLOSED;
                    restart[IDX_PRE] = 1'b1;
                end else begin
                    trk_d.viol = 1'b1;
                end
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q <= trk_rst;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign bank_open_o = (trk_q.st == BK_OPEN) || (trk_q.st == BK_CLOSING);
    assign pre_busy_o  = (trk_q.st == BK_CLOSED) && !rp_met;
    assign act_ok_o    = act_ok;
    assign viol_o      = trk_q.viol;

endmodule

// File: rtl/rdap_bank_tracker_chk.sv
module rdap_bank_tracker_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] cmd_i,
    input logic       bank_open_o,
    input logic       pre_busy_o,
    input logic       act_ok_o,
    input logic       dvalid_o,
    input logic       dqs_pre_o,
    input logic       viol_o
);
    import bktrk_pkg::*;

    assert_open_after_legal_act_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        $rose(bank_open_o) |-> $past(act_ok_o)
    );

    assert_act_only_when_closed_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        act_ok_o |-> !bank_open_o
    );

    assert_busy_blocks_act_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        pre_busy_o |-> (!bank_open_o && !act_ok_o)
    );

    assert_preamble_not_in_window_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        dqs_pre_o |-> !dvalid_o
    );

    assert_preamble_then_data_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        dqs_pre_o |=> dvalid_o
    );

    assert_early_act_flags_R10: assert property (
        @(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_ACT && !act_ok_o) |=> viol_o
    );

    assert_viol_sticky_R10: assert property (
        @(posedge clk) disable iff (!rst_n)
        viol_o |=> viol_o
    );

    assert_viol_needs_command_R11: assert property (
        @(posedge clk) disable iff (!rst_n)
        $rose(viol_o) |-> ($past(cmd_i) inside {CMD_ACT, CMD_RD, CMD_RDA, CMD_PRE})
    );

endmodule

bind rdap_bank_tracker rdap_bank_tracker_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_i       (cmd_i),
    .bank_open_o (bank_open_o),
    .pre_busy_o  (pre_busy_o),
    .act_ok_o    (act_ok_o),
    .dvalid_o    (dvalid_o),
    .dqs_pre_o   (dqs_pre_o),
    .viol_o      (viol_o)
);

// File: tb/rdap_bank_tracker_tb.sv
`timescale 1ns/1ps
module rdap_bank_tracker_tb;
    import bktrk_pkg::*;

    localparam int TW = 5;
    localparam int K_OPEN = 0, K_BUSY = 1, K_ACTOK = 2, K_DV = 3, K_PRE = 4, K_VIOL = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    cmd = CMD_DES;
    logic          chop = 1'b0;
    logic [TW-1:0] cl = '0, al = '0, trp = '0, tras = '0, trc = '0;
    logic [2:0]    code = '0;
    logic          bank_open, pre_busy, act_ok, dvalid, dqs_pre, viol;

    rdap_bank_tracker #(.TW(TW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .chop_i(chop),
        .cl_i(cl), .al_i(al), .trp_i(trp), .tras_i(tras), .trc_i(trc),
        .rtp_code_i(code),
        .bank_open_o(bank_open), .pre_busy_o(pre_busy), .act_ok_o(act_ok),
        .dvalid_o(dvalid), .dqs_pre_o(dqs_pre), .viol_o(viol)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    at;
        int    kind;
        bit    val;
        string tag;
    } exp_t;

    exp_t  sbq[$];
    int    n_chk = 0;
    int    n_fail = 0;
    string kname[6] = '{"bank_open", "pre_busy", "act_ok", "dvalid", "dqs_pre", "viol"};

    function automatic bit pick(int kind);
        case (kind)
            K_OPEN:  return bank_open;
            K_BUSY:  return pre_busy;
            K_ACTOK: return act_ok;
            K_DV:    return dvalid;
            K_PRE:   return dqs_pre;
            default: return viol;
        endcase
    endfunction

    task automatic expect_at(input int at, input int kind, input bit val, input string tag);
        exp_t e;
        e.at = at; e.kind = kind; e.val = val; e.tag = tag;
        sbq.push_back(e);
    endtask

    // Monitor: pop and compare every item due in this cycle.
    always @(negedge clk) begin
        for (int i = sbq.size() - 1; i >= 0; i--) begin
            if (sbq[i].at == cyc) begin
                n_chk++;
                if (pick(sbq[i].kind) !== sbq[i].val) begin
                    n_fail++;
                    $display("FAIL %s cycle %0d %s actual=%0b expected=%0b",
                             sbq[i].tag, cyc, kname[sbq[i].kind], pick(sbq[i].kind), sbq[i].val);
                end
                sbq.delete(i);
            end
        end
    end

    task automatic step(input logic [2:0] c, input logic ch, output int t);
        @(negedge clk);
        cmd  = c;
        chop = ch;
        t    = cyc;
    endtask

    task automatic idle_until(input int t);
        int dummy;
        while (cyc + 1 < t) step(CMD_DES, 1'b0, dummy);
    endtask

    task automatic do_reset(input int c_cl, input int c_al, input int c_rp, input int c_ras,
                            input int c_rc, input int c_code, output int t);
        @(negedge clk);
        rst_n = 1'b0;
        cmd   = CMD_DES;
        chop  = 1'b0;
        cl = TW'(c_cl); al = TW'(c_al); trp = TW'(c_rp);
        tras = TW'(c_ras); trc = TW'(c_rc); code = 3'(c_code);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Live inputs change after reset; they must not matter (R12).
        cl = TW'(3); al = TW'(1); trp = TW'(2); tras = TW'(2); trc = TW'(3); code = 3'd0;
        t = cyc;
    endtask

    function automatic int rtp_of(input int c);
        return (c <= 5) ? 5 + c : 12;
    endfunction

    function automatic int max2(input int x, input int y);
        return (x > y) ? x : y;
    endfunction

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d cycles expected=finish earlier", cyc);
        finish_run();
    end

    initial begin
        int t0, a, r, r1, r2, p, s, ta, d, rl, trtp;

        // ---------------- Phase 1: RL 11, tRP 11, tRAS 14, tRC 28, code 1 ----------------
        do_reset(11, 0, 11, 14, 28, 1, t0);
        rl = 11; trtp = rtp_of(1);
        expect_at(t0 + 1, K_OPEN,  1'b0, "R1");
        expect_at(t0 + 1, K_ACTOK, 1'b1, "R1");
        expect_at(t0 + 1, K_BUSY,  1'b0, "R1");
        expect_at(t0 + 1, K_DV,    1'b0, "R1");
        expect_at(t0 + 1, K_VIOL,  1'b0, "R1");

        // Test A: activate, two back-to-back full reads, explicit precharge.
        step(CMD_ACT, 1'b0, a);
        expect_at(a + 1, K_OPEN,  1'b1, "R2");
        expect_at(a + 1, K_ACTOK, 1'b0, "R2");
        idle_until(a + 2);
        step(CMD_RD, 1'b0, r1);
        idle_until(r1 + 4);
        step(CMD_RD, 1'b0, r2);
        expect_at(r1 + 4, K_DV, 1'b0, "R12");
        expect_at(r1 + rl - 1, K_PRE, 1'b1, "R5");
        expect_at(r1 + rl - 1, K_DV,  1'b0, "R3");
        for (int k = 0; k < 8; k++) expect_at(r1 + rl + k, K_DV, 1'b1, "R3");
        expect_at(r1 + rl + 8, K_DV, 1'b0, "R3");
        expect_at(r2 + rl - 1, K_PRE, 1'b0, "R5");
        p = max2(a + 14, r2 + trtp);
        idle_until(p);
        step(CMD_PRE, 1'b0, d);
        expect_at(p + 1, K_OPEN, 1'b0, "R9");
        expect_at(p + 1, K_BUSY, 1'b1, "R9");
        expect_at(p + 10, K_BUSY, 1'b1, "R8");
        expect_at(p + 11, K_BUSY, 1'b0, "R8");
        ta = max2(p + 11, a + 28);
        expect_at(ta - 1, K_ACTOK, 1'b0, "R8");
        expect_at(ta, K_ACTOK, 1'b1, "R8");
        expect_at(ta, K_VIOL, 1'b0, "R9");
        idle_until(ta + 1);

        // Test B: chopped auto-precharge read right after activate; tRAS then tRC dominate.
        step(CMD_ACT, 1'b0, a);
        step(CMD_RDA, 1'b1, r);
        s = max2(r + trtp, a + 14);
        expect_at(r + rl - 1, K_PRE, 1'b1, "R5");
        expect_at(r + rl,     K_DV, 1'b1, "R4");
        expect_at(r + rl + 1, K_DV, 1'b1, "R4");
        expect_at(r + rl + 2, K_DV, 1'b0, "R4");
        expect_at(s,      K_OPEN, 1'b1, "R7");
        expect_at(s + 1,  K_OPEN, 1'b0, "R7");
        expect_at(s + 1,  K_BUSY, 1'b1, "R7");
        expect_at(s + 10, K_BUSY, 1'b1, "R7");
        expect_at(s + 11, K_BUSY, 1'b0, "R8");
        ta = max2(s + 11, a + 28);
        expect_at(ta - 1, K_ACTOK, 1'b0, "R8");
        expect_at(ta,     K_ACTOK, 1'b1, "R8");
        idle_until(ta + 1);

        // Test C: late auto-precharge read; tRTP then tRP dominate; reserved codes in between.
        step(CMD_ACT, 1'b0, a);
        idle_until(a + 12);
        step(CMD_RDA, 1'b0, r);
        step(3'd6, 1'b0, d);
        step(3'd5, 1'b1, d);
        step(3'd7, 1'b0, d);
        s = max2(r + trtp, a + 14);
        expect_at(r + 4, K_VIOL, 1'b0, "R11");
        expect_at(r + rl,     K_DV, 1'b1, "R3");
        expect_at(r + rl + 3, K_DV, 1'b1, "R3");
        expect_at(r + rl + 4, K_DV, 1'b0, "R3");
        expect_at(s,      K_OPEN, 1'b1, "R7");
        expect_at(s + 1,  K_OPEN, 1'b0, "R7");
        expect_at(s + 10, K_BUSY, 1'b1, "R7");
        expect_at(s + 11, K_BUSY, 1'b0, "R8");
        ta = max2(s + 11, a + 28);
        expect_at(ta - 1, K_ACTOK, 1'b0, "R8");
        expect_at(ta,     K_ACTOK, 1'b1, "R8");
        expect_at(ta,     K_VIOL,  1'b0, "R11");
        idle_until(ta + 1);

        // ---------------- Phase 2: RL 13, tRP 4, tRAS 5, tRC 8, code 7 ----------------
        do_reset(10, 3, 4, 5, 8, 7, t0);
        rl = 13; trtp = rtp_of(7);
        expect_at(t0 + 1, K_VIOL,  1'b0, "R1");
        expect_at(t0 + 1, K_ACTOK, 1'b1, "R1");

        // Test D: fallback read-to-precharge delay of 12.
        step(CMD_ACT, 1'b0, a);
        step(CMD_RDA, 1'b0, r);
        s = max2(r + trtp, a + 5);
        expect_at(s,     K_OPEN, 1'b1, "R6");
        expect_at(s + 1, K_OPEN, 1'b0, "R6");
        expect_at(r + rl - 1, K_DV,  1'b0, "R12");
        expect_at(r + rl - 1, K_PRE, 1'b1, "R5");
        expect_at(r + rl,     K_DV,  1'b1, "R12");
        ta = max2(s + 4, a + 8);
        expect_at(ta - 1, K_ACTOK, 1'b0, "R8");
        expect_at(ta,     K_ACTOK, 1'b1, "R8");
        idle_until(ta);

        // Test E: illegal commands set the flag and are dropped.
        step(CMD_ACT, 1'b0, a);
        step(CMD_ACT, 1'b0, d);
        expect_at(a + 1, K_VIOL, 1'b0, "R10");
        expect_at(a + 2, K_VIOL, 1'b1, "R10");
        expect_at(a + 2, K_OPEN, 1'b1, "R10");
        step(CMD_PRE, 1'b0, d);
        expect_at(a + 3, K_OPEN, 1'b1, "R10");
        step(CMD_RD, 1'b0, r);
        step(CMD_RD, 1'b0, d);
        for (int k = 0; k < 4; k++) expect_at(r + rl + k, K_DV, 1'b1, "R10");
        expect_at(r + rl + 4, K_DV, 1'b0, "R10");
        expect_at(r + rl + 6, K_VIOL, 1'b1, "R10");
        idle_until(r + rl + 8);

        repeat (2) @(negedge clk);
        if (sbq.size() != 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL scoreboard actual=%0d pending expected=0", sbq.size());
        end
        finish_run();
    end

endmodule